// File: doc/BRIEF.md
# Signalling Voltage Switch Sequencer

This block runs the host side of moving an SD bus from 3.3 V to 1.8 V signalling. It starts after the voltage-switch command (index 11) has completed. The command engine gives it a one-cycle completion strobe, the index of the command that finished, and a flag that says whether the command succeeded. On success the block raises the voltage-select output and then waits a settle time measured in microseconds. After that it forces the card clock to run and keeps it running until the card releases DAT0 high. It then drops the forced clock, leaves voltage select set, and pulses done.

If the switch command fails, the host must not change the signalling level. The block leaves voltage select alone and raises a sticky flag saying the card needs a power cycle. An optional watchdog limits the forced-clock window. If DAT0 never rises within that window, the block ends the sequence and raises a sticky timeout flag. The DAT0 input is asynchronous to the block clock and passes through a synchronizer of configurable depth.

Top module: `vsw_seq`

## Requirements
- R1: A sequence starts only on a `start_i` strobe taken while idle, with `cmd_idx_i` equal to 11 and `cmd_ok_i` high. Strobes with any other index, and any strobe taken while busy, change no output.
- R2: A strobe with index 11 and `cmd_ok_i` low, taken while idle, sets `pwr_cycle_o` in the next cycle and leaves `vsel_o` unchanged. `pwr_cycle_o` stays high until the next successful index-11 strobe is accepted.
- R3: `vsel_o` rises in the cycle after an accepted successful strobe. After that only reset clears it.
- R4: `force_clk_o` rises exactly SETTLE_CYC cycles after `vsel_o` rises, where SETTLE_CYC = CLK_HZ*SETTLE_US/1000000.
- R5: `force_clk_o` stays high until DAT0 is seen high. If `dat0_i` is captured high at clock edge E while the forced clock is on, `force_clk_o` falls and `done_o` pulses after edge E+SYNC_STAGES. A DAT0 level present during the settle wait has no effect until the forced-clock phase.
- R6: `busy_o` is high from the cycle after an accepted successful strobe until the end of the sequence. `done_o` is a single-cycle pulse in the first cycle in which `busy_o` is low again.
- R7: With WDOG_CYC > 0, if DAT0 is not seen high, `force_clk_o` stays high for exactly WDOG_CYC cycles, then falls. `done_o` pulses and `timeout_o` is set at the same time. `timeout_o` clears when the next index-11 strobe is accepted.
- R8: While `rst_n` is low, and right after it is released, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe: a command has completed |
| cmd_idx_i | input | IDX_W | Index of the completed command |
| cmd_ok_i | input | 1 | Completed command had no error |
| dat0_i | input | 1 | DAT0 line level (asynchronous) |
| vsel_o | output | 1 | Select 1.8 V signalling |
| force_clk_o | output | 1 | Keep card clock running regardless of gating |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at end of sequence |
| pwr_cycle_o | output | 1 | Switch command failed; card needs power cycle |
| timeout_o | output | 1 | DAT0 never released within the watchdog window |

## Verification
A wrong phase or a wrong counter value shows first in the timing of `force_clk_o`. A settle count that is off by one moves its rising edge relative to `vsel_o` by a cycle. A synchronizer of the wrong depth moves its falling edge relative to the DAT0 transition. A flag that is not cleared or not held shows in `pwr_cycle_o` or `timeout_o` on the cycle after the next strobe. A reference model steps on every clock and is compared against all six outputs on every cycle. Because of that, any divergence is reported in the cycle it first appears, not at the end of a sequence.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_FORCE  = 2'd2
    } vsw_phase_e;

    typedef struct packed {
        vsw_phase_e phase;
        logic       vsel;
        logic       force_clk;
        logic       busy;
        logic       done;
        logic       pwr;
        logic       tmo;
    } vsw_state_t;

endpackage

// File: rtl/vsw_sync.sv
module vsw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/vsw_tick.sv
module vsw_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                 cnt_d = '0;
        else if (cnt_q != limit_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_o = (cnt_q == limit_i);

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_q != limit_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
    AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/vsw_seq.sv
module vsw_seq
    import vsw_pkg::*;
#(
    parameter int CLK_HZ      = 125_000_000,
    parameter int SETTLE_US   = 5000,
    parameter int WDOG_CYC    = 4096,
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 6,
    parameter int SWITCH_IDX  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] cmd_idx_i,
    input  logic             cmd_ok_i,
    input  logic             dat0_i,
    output logic             vsel_o,
    output logic             force_clk_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             pwr_cycle_o,
    output logic             timeout_o
);
    localparam longint SETTLE_CYC = (longint'(CLK_HZ) * longint'(SETTLE_US)) / 64'd1000000;
    localparam longint MAX_CYC    = (SETTLE_CYC > longint'(WDOG_CYC)) ? SETTLE_CYC : longint'(WDOG_CYC);
    localparam int     CNT_W      = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] WD_LIM  = (WDOG_CYC > 0) ? CNT_W'(WDOG_CYC - 1) : '0;

    vsw_state_t       s_d, s_q;
    logic             dat0_s;
    logic             tick_hit;
    logic             wd_hit;
    logic             tmr_clr;
    logic [CNT_W-1:0] lim;
    logic             cmd_match;

    assign cmd_match = start_i && (cmd_idx_i == IDX_W'(SWITCH_IDX));

    vsw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dat0_i),
        .q_o   (dat0_s)
    );

    vsw_tick #(.W(CNT_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .limit_i (lim),
        .hit_o   (tick_hit)
    );

    generate
        if (WDOG_CYC > 0) begin : g_wdog
            assign wd_hit = tick_hit;
        end else begin : g_nowdog
            assign wd_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        lim = (s_q.phase == PH_SETTLE) ? SET_LIM : WD_LIM;
        s_d = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (cmd_match) begin
                    s_d.tmo = 1'b0;
                    if (cmd_ok_i) begin
                        s_d.phase = PH_SETTLE;
                        s_d.vsel  = 1'b1;
                        s_d.busy  = 1'b1;
                        s_d.pwr   = 1'b0;
                    end else begin
                        s_d.pwr   = 1'b1;
                    end
                end
            end
            PH_SETTLE: begin
                if (tick_hit) begin
                    s_d.phase     = PH_FORCE;
                    s_d.force_clk = 1'b1;
                end
            end
            PH_FORCE: begin
                if (dat0_s) begin
                    s_d.phase     = PH_IDLE;
                    s_d.force_clk = 1'b0;
                    s_d.busy      = 1'b0;
                    s_d.done      = 1'b1;
                end else if (wd_hit) begin
                    s_d.phase     = PH_IDLE;
                    s_d.force_clk = 1'b0;
                    s_d.busy      = 1'b0;
                    s_d.done      = 1'b1;
                    s_d.tmo       = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
        tmr_clr = (s_q.phase == PH_IDLE) || (s_d.phase != s_q.phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, default: 1'b0};
        else        s_q <= s_d;
    end

    assign vsel_o      = s_q.vsel;
    assign force_clk_o = s_q.force_clk;
    assign busy_o      = s_q.busy;
    assign done_o      = s_q.done;
    assign pwr_cycle_o = s_q.pwr;
    assign timeout_o   = s_q.tmo;

    AST_FORCE_NEEDS_VSEL: assert property (@(posedge clk) disable iff (!rst_n)
        force_clk_o |-> vsel_o); // R4
    AST_VSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        vsel_o |=> vsel_o); // R3
    AST_FAIL_KEEPS_VSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_match && !cmd_ok_i && !busy_o) |=> (vsel_o == $past(vsel_o) && pwr_cycle_o)); // R2
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R6
    AST_FORCE_DROP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_clk_o) |-> done_o); // R5
    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> done_o); // R7
endmodule

// File: tb/vsw_seq_bench.sv
module vsw_seq_bench;
    localparam int CLK_HZ  = 1_000_000;
    localparam int SET_US  = 200;
    localparam int WD      = 64;
    localparam int SYNC    = 2;
    localparam int N_SET   = CLK_HZ / 1_000_000 * SET_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [5:0] idx = '0;
    logic ok = 1'b0;
    logic dat0 = 1'b0;
    logic vsel, fclk, busy, done, pwr, tmo;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    vsw_seq #(.CLK_HZ(CLK_HZ), .SETTLE_US(SET_US), .WDOG_CYC(WD),
              .SYNC_STAGES(SYNC), .IDX_W(6), .SWITCH_IDX(11)) u_vsw_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_idx_i(idx),
        .cmd_ok_i(ok), .dat0_i(dat0), .vsel_o(vsel), .force_clk_o(fclk),
        .busy_o(busy), .done_o(done), .pwr_cycle_o(pwr), .timeout_o(tmo));

    // behavioural reference model
    int m_ph, m_cnt, m_d1, m_d2;
    bit m_vsel, m_fclk, m_busy, m_done, m_pwr, m_tmo;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_d1 = 0; m_d2 = 0;
            m_vsel = 0; m_fclk = 0; m_busy = 0; m_done = 0; m_pwr = 0; m_tmo = 0;
        end else begin
            int seen;
            cyc++;
            seen = m_d2; m_d2 = m_d1; m_d1 = int'(dat0);
            m_done = 0;
            if (m_ph == 0) begin
                if (start && idx == 6'd11) begin
                    m_tmo = 0;
                    if (ok) begin
                        m_ph = 1; m_cnt = 0; m_vsel = 1; m_busy = 1; m_pwr = 0;
                    end else m_pwr = 1;
                end
            end else if (m_ph == 1) begin
                if (m_cnt == N_SET - 1) begin m_ph = 2; m_cnt = 0; m_fclk = 1; end
                else m_cnt++;
            end else begin
                if (seen != 0) begin
                    m_ph = 0; m_fclk = 0; m_busy = 0; m_done = 1;
                end else if (m_cnt == WD - 1) begin
                    m_ph = 0; m_fclk = 0; m_busy = 0; m_done = 1; m_tmo = 1;
                end else m_cnt++;
            end
        end
    end

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(vsel == m_vsel, "R3 vsel_o vs model", vsel, m_vsel);
            chk(fclk == m_fclk, "R4,R5 force_clk_o vs model", fclk, m_fclk);
            chk(busy == m_busy, "R1,R6 busy_o vs model", busy, m_busy);
            chk(done == m_done, "R6 done_o vs model", done, m_done);
            chk(pwr  == m_pwr,  "R2 pwr_cycle_o vs model", pwr, m_pwr);
            chk(tmo  == m_tmo,  "R7 timeout_o vs model", tmo, m_tmo);
        end
    end

    task automatic strobe(input int i, input bit k);
        start = 1'b1; idx = 6'(i); ok = k;
        @(negedge clk);
        start = 1'b0; idx = '0; ok = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk({vsel, fclk, busy, done, pwr, tmo} == 6'b0, "R8 outputs in reset", {vsel, fclk, busy, done, pwr, tmo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({vsel, fclk, busy, done, pwr, tmo} == 6'b0, "R8 outputs after reset", {vsel, fclk, busy, done, pwr, tmo}, 0);

        // R1: other index ignored
        strobe(7, 1'b1);
        @(negedge clk);
        chk(!busy && !vsel, "R1 index 7 ignored", busy, 0);

        // R2: failed switch command
        strobe(11, 1'b0);
        chk(pwr && !vsel, "R2 fail sets pwr, vsel held low", {pwr, vsel}, 2);

        // R3/R4/R5: good sequence with a strobe while busy and a DAT0 blip in settle
        strobe(11, 1'b1);
        t0 = cyc;
        chk(vsel && busy && !pwr, "R3 vsel rises after accepted strobe", {vsel, busy, pwr}, 6);
        repeat (2) @(negedge clk);
        strobe(11, 1'b0);
        chk(!pwr, "R1 strobe while busy ignored", pwr, 0);
        dat0 = 1'b1;
        repeat (5) @(negedge clk);
        dat0 = 1'b0;
        while (!fclk) @(negedge clk);
        chk(cyc - t0 == N_SET, "R4 settle length", cyc - t0, N_SET);
        repeat (10) @(negedge clk);
        chk(fclk, "R5 force held while DAT0 low", fclk, 1);
        dat0 = 1'b1;
        t0 = cyc;
        while (fclk) @(negedge clk);
        chk(cyc - t0 == SYNC + 1, "R5 force drop latency", cyc - t0, SYNC + 1);
        chk(done && !busy && vsel, "R6 done with busy low", {done, busy, vsel}, 5);
        dat0 = 1'b0;
        @(negedge clk);
        chk(!done, "R6 done single cycle", done, 0);

        // R7: watchdog
        strobe(11, 1'b1);
        while (!fclk) @(negedge clk);
        t0 = cyc;
        while (fclk) @(negedge clk);
        chk(cyc - t0 == WD, "R7 forced window length", cyc - t0, WD);
        chk(tmo && done && vsel, "R7 timeout with done", {tmo, done, vsel}, 7);

        // R5: DAT0 already high during settle, R7 timeout cleared on accept
        dat0 = 1'b1;
        @(negedge clk);
        strobe(11, 1'b1);
        chk(!tmo, "R7 timeout cleared on accept", tmo, 0);
        while (!fclk) @(negedge clk);
        @(negedge clk);
        chk(!fclk && done, "R5 one-cycle force when DAT0 already high", {fclk, done}, 1);
        dat0 = 1'b0;

        // R2: failure after vsel set keeps vsel
        @(negedge clk);
        strobe(11, 1'b0);
        chk(pwr && vsel, "R2 fail keeps vsel high", {pwr, vsel}, 3);

        // R8: reset mid-sequence
        strobe(11, 1'b1);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({vsel, fclk, busy, done, pwr, tmo} == 6'b0, "R8 reset mid-sequence", {vsel, fclk, busy, done, pwr, tmo}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!vsel && !busy, "R8 idle after reset", {vsel, busy}, 0);
        finish_run();
    end
endmodule